// File: doc/BRIEF.md
# Signed Word-Width Reducer with Selectable Quantisation

This block takes a full-precision signed result, for example from a decimating or interpolating filter, and returns a narrower signed word. A parameter selects one of five quantisation modes. Full-resolution pass-through keeps the input unchanged. Truncation and two rounding modes discard low-order bits. Saturation discards high-order bits and clamps values that do not fit.

The input is a signed word with a valid flag. The result is registered, so it appears one clock later with its own valid flag. Between valid inputs the output register keeps its last value.

The mode codes are: 0 full resolution, 1 truncation, 2 convergent rounding (round half to even), 3 round half up, 4 saturation. In mode 0 the output width equals the input width and `OUT_W` is ignored. In the other modes `OUT_W` may be anything from 1 to `IN_W`. The number of discarded bits is D = `IN_W` − `OUT_W`.

Top module: `word_width_reducer`

## Requirements
- R1: `dout_valid` equals the `din_valid` value sampled at the previous rising clock edge.
- R2: While `rst_n` is low, `dout` and `dout_valid` are 0. After a clock edge at which `din_valid` is low, `dout` keeps its previous value.
- R3: Mode 0 outputs the input unchanged, at `IN_W` bits wide.
- R4: Mode 1 outputs floor(din / 2^D), which rounds toward negative infinity.
- R5: Mode 3 outputs the nearest value of din / 2^D. Exact half-way values go toward positive infinity.
- R6: Mode 2 outputs the nearest value of din / 2^D. Exact half-way values go to the even output code, meaning bit 0 of `dout` is 0.
- R7: In modes 2 and 3, a result that would exceed the largest `OUT_W`-bit signed value, 2^(OUT_W−1)−1, is clamped to that value.
- R8: Mode 4 keeps the weight of the input LSB. An input inside the `OUT_W`-bit signed range is output unchanged.
- R9: In mode 4, an input above 2^(OUT_W−1)−1 gives 2^(OUT_W−1)−1, and an input below −2^(OUT_W−1) gives −2^(OUT_W−1).
- R10: In mode 4 with `OUT_W` = 1, every non-negative input gives 0 and every negative input gives −1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din_valid | input | 1 | Input word is valid this cycle |
| din | input | IN_W | Full-precision signed input |
| dout_valid | output | 1 | Registered output valid |
| dout | output | IN_W in mode 0, else OUT_W | Reduced signed output |

## Verification
The assertions assume the parameters are legal: `OUT_W` between 1 and `IN_W`, and `MODE` between 0 and 4. They also assume that `din` is a known value whenever `din_valid` is high. The bench holds one set of parameters per instance. It drives every input code as a defined two's-complement value, changing inputs only on the falling edge, so a known input is always sampled. It sweeps the complete input range, and that sweep includes every exact half-way value and every overflow value.

// File: rtl/word_width_reducer.sv
module word_width_reducer #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 12,
  parameter int MODE  = 2
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        din_valid,
  input  logic signed [IN_W-1:0]                      din,
  output logic                                        dout_valid,
  output logic signed [((MODE == 0) ? IN_W : OUT_W)-1:0] dout
);

  localparam int OW = (MODE == 0) ? IN_W : OUT_W;
  localparam int D  = IN_W - OW;
  localparam logic signed [OW-1:0] MINV = OW'(64'd1 << (OW - 1));
  localparam logic signed [OW-1:0] MAXV = ~MINV;

  logic signed [OW-1:0] q;

  generate
    if (MODE == 0 || D == 0) begin : g_pass
      assign q = din[OW-1:0];
    end else if (MODE == 1) begin : g_trunc
      assign q = din[IN_W-1:D];
    end else if (MODE == 2 || MODE == 3) begin : g_round
      logic [IN_W:0] inc;
      logic [IN_W:0] sum;
      logic [OW:0]   wide;
      if (MODE == 3) begin : g_up
        assign inc = (IN_W+1)'(1) << (D - 1);
      end else begin : g_even
        assign inc = ((IN_W+1)'(1) << (D - 1)) - (IN_W+1)'(1) + (IN_W+1)'(din[D]);
      end
      assign sum  = {din[IN_W-1], din} + inc;
      assign wide = sum[IN_W:D];
      assign q    = (wide[OW] != wide[OW-1]) ? MAXV : wide[OW-1:0];
    end else begin : g_sat
      logic fits;
      assign fits = (&din[IN_W-1:OW-1]) | ~(|din[IN_W-1:OW-1]);
      assign q    = fits ? din[OW-1:0] : (din[IN_W-1] ? MINV : MAXV);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_valid <= 1'b0;
      dout       <= '0;
    end else begin
      dout_valid <= din_valid;
      if (din_valid) dout <= q;
    end
  end

  a_r1_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    din_valid |=> dout_valid);
  a_r1_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !din_valid |=> !dout_valid);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !din_valid |=> $stable(dout));

  generate
    if (MODE == 0 || D == 0) begin : g_chk_pass
      a_r3_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        din_valid |=> (dout == $past(din[OW-1:0])));
    end else if (MODE == 1) begin : g_chk_trunc
      a_r4_not_above: assert property (@(posedge clk) disable iff (!rst_n)
        din_valid |=> ($signed({dout, {D{1'b0}}}) <= $past(din)));
    end else if (MODE == 2 || MODE == 3) begin : g_chk_round
      localparam logic [D-1:0] HALF = D'(1) << (D - 1);
      localparam logic signed [IN_W-1:0] TOPIN = ~(IN_W'(64'd1 << (IN_W - 1)));
      a_r7_clamp_top: assert property (@(posedge clk) disable iff (!rst_n)
        (din_valid && din == TOPIN) |=> (dout == MAXV));
      if (MODE == 2) begin : g_chk_even
        a_r6_tie_even: assert property (@(posedge clk) disable iff (!rst_n)
          (din_valid && din[D-1:0] == HALF) |=> (!dout[0] || dout == MAXV));
      end else begin : g_chk_up
        a_r5_tie_up: assert property (@(posedge clk) disable iff (!rst_n)
          (din_valid && din[D-1:0] == HALF) |=>
            (dout == MAXV || $signed({dout[OW-1], dout, {D{1'b0}}}) > $signed({$past(din[IN_W-1]), $past(din)})));
      end
    end else begin : g_chk_sat
      a_r9_pos_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (din_valid && !din[IN_W-1] && (|din[IN_W-1:OW-1])) |=> (dout == MAXV));
      a_r9_neg_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (din_valid && din[IN_W-1] && !(&din[IN_W-1:OW-1])) |=> (dout == MINV));
    end
  endgenerate

endmodule

// File: tb/word_width_reducer_tb.sv
module word_width_reducer_tb;
  localparam int IW = 8;
  localparam int OWD = 5;
  localparam int DB = IW - OWD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vin = 1'b0;
  logic signed [IW-1:0] din = '0;
  logic signed [3:0] din4 = '0;

  logic v_conv, v_none, v_trunc, v_up, v_sat, v_sat1;
  logic signed [OWD-1:0] o_conv, o_trunc, o_up, o_sat;
  logic signed [IW-1:0]  o_none;
  logic signed [0:0]     o_sat1;

  int vectors = 0;
  int errors  = 0;

  always #10 clk = ~clk;

  word_width_reducer #(.IN_W(IW), .OUT_W(OWD), .MODE(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .din_valid(vin), .din(din), .dout_valid(v_conv), .dout(o_conv));
  word_width_reducer #(.IN_W(IW), .OUT_W(OWD), .MODE(0)) u_dut_none (
    .clk(clk), .rst_n(rst_n), .din_valid(vin), .din(din), .dout_valid(v_none), .dout(o_none));
  word_width_reducer #(.IN_W(IW), .OUT_W(OWD), .MODE(1)) u_dut_trunc (
    .clk(clk), .rst_n(rst_n), .din_valid(vin), .din(din), .dout_valid(v_trunc), .dout(o_trunc));
  word_width_reducer #(.IN_W(IW), .OUT_W(OWD), .MODE(3)) u_dut_up (
    .clk(clk), .rst_n(rst_n), .din_valid(vin), .din(din), .dout_valid(v_up), .dout(o_up));
  word_width_reducer #(.IN_W(IW), .OUT_W(OWD), .MODE(4)) u_dut_sat (
    .clk(clk), .rst_n(rst_n), .din_valid(vin), .din(din), .dout_valid(v_sat), .dout(o_sat));
  word_width_reducer #(.IN_W(4), .OUT_W(1), .MODE(4)) u_dut_sat1 (
    .clk(clk), .rst_n(rst_n), .din_valid(vin), .din(din4), .dout_valid(v_sat1), .dout(o_sat1));

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int clampv(input int v, input int lo, input int hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  function automatic int fl(input int x);
    return x >>> DB;
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int mx;
    int mn;
    mx = (1 << (OWD - 1)) - 1;
    mn = -(1 << (OWD - 1));
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2 reset valid", int'(v_conv), 0);
    check("R2 reset dout", int'(o_conv), 0);
    check("R2 reset dout sat", int'(o_sat), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < (1 << IW); i++) begin
      int x;
      int q;
      int r;
      int x4;
      din  = IW'(i);
      din4 = 4'(i);
      vin  = 1'b1;
      x    = int'(din);
      x4   = int'(din4);
      @(negedge clk);
      check("R1 valid", int'(v_conv) + int'(v_up) + int'(v_sat1), 3);
      check("R3 none", int'(o_none), x);
      check("R4 trunc", int'(o_trunc), fl(x));
      check("R5/R7 round up", int'(o_up), clampv(fl(x + (1 << (DB - 1))), mn, mx));
      q = fl(x);
      r = x - (q << DB);
      if (r > (1 << (DB - 1)) || (r == (1 << (DB - 1)) && (q & 1) != 0)) q = q + 1;
      check("R6/R7 convergent", int'(o_conv), clampv(q, mn, mx));
      if (x >= mn && x <= mx) check("R8 sat in range", int'(o_sat), x);
      else check("R9 sat clamp", int'(o_sat), clampv(x, mn, mx));
      check("R10 sat 1-bit", int'(o_sat1), (x4 < 0) ? -1 : 0);
    end
    // R2: hold while invalid, R1: valid drops
    for (int k = 0; k < 4; k++) begin
      int pc;
      int ps;
      pc = int'(o_conv);
      ps = int'(o_sat);
      vin = 1'b0;
      din = IW'(37 * k - 60);
      @(negedge clk);
      check("R1 valid low", int'(v_conv), 0);
      check("R2 hold conv", int'(o_conv), pc);
      check("R2 hold sat", int'(o_sat), ps);
      vin = 1'b1;
      @(negedge clk);
      check("R1 valid high", int'(v_conv), 1);
      check("R9 sat after gap", int'(o_sat), clampv(int'(din), mn, mx));
    end
    finish_run();
  end
endmodule